// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This block is a one-stage integer datapath that treats each 64-bit operand as a row of independent lanes. The lanes can be eight bytes, four halfwords or two words. Every lane is computed on its own, and no carry, borrow or shifted-out bit crosses from one lane into the next.

The operations are:
- add and subtract, either wrapping or clamped at the lane limits, in signed or unsigned mode;
- bitwise logic;
- per-lane shifts, with the shift amount for each lane taken from the same lane of operand B;
- equality and greater-than compares, which return a full lane mask;
- pack, which narrows lanes to half their width with clamping.

The inputs are the two operands, a 4-bit opcode, a 2-bit lane-size code and a signed flag. They are sampled on a rising clock edge. The 64-bit result appears from the output register on the following cycle. The block is meant to sit in the execute stage of a core with short-vector support, where the register file and the decoder supply its inputs.

Top module: `simd_alu`

## Requirements
- R1: While `rst_n` is low at a rising edge, `result` is zero after that edge. Otherwise `result` holds the outcome for the inputs sampled at the previous rising edge.
- R2: Lane-size code 0 selects eight 8-bit lanes, code 1 selects four 16-bit lanes, and code 2 selects two 32-bit lanes. Code 3 behaves as code 2. Wrapping add (opcode 0) and wrapping subtract (opcode 2) compute each lane modulo its width, with no carry or borrow crossing a lane boundary.
- R3: Saturating add (opcode 1) and saturating subtract (opcode 3) clamp instead of wrapping.
  - With `is_signed` high, an overflowing lane becomes the most positive or most negative value of the lane.
  - With `is_signed` low, add clamps to all ones and subtract clamps to zero.
- R4: Opcode 4 gives A AND B, opcode 5 gives (NOT A) AND B, opcode 6 gives A OR B, and opcode 7 gives A XOR B. The lane-size code has no effect on these opcodes.
- R5: Opcode 11 (equal) and opcode 12 (greater-than, A > B) set each lane to all ones when the test is true and to all zeros when it is false. Greater-than compares as two's complement when `is_signed` is high and as unsigned otherwise.
- R6: Opcode 8 (shift left), opcode 9 (logical shift right) and opcode 10 (arithmetic shift right) shift each lane of A by the unsigned value in the same lane of B. An amount equal to or larger than the lane width gives zero for the logical shifts and a copy of the sign bit in every position for the arithmetic shift.
- R7: Pack (opcode 13) narrows lanes to half width.
  - Size code 1 narrows 16-bit lanes to 8 bits. Size code 2 or 3 narrows 32-bit lanes to 16 bits. Size code 0 gives zero.
  - The narrowed lanes of A fill the low 32 bits of the result and those of B fill the high 32 bits, each in lane order.
  - With `is_signed` high, values are clamped to the signed range of the narrow lane. With `is_signed` low, the source is read as unsigned and clamped to the narrow maximum.
- R8: Opcodes 14 and 15 give a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_a | input | 64 | Operand A |
| op_b | input | 64 | Operand B; also supplies the per-lane shift amounts |
| opcode | input | 4 | Operation select |
| lane_size | input | 2 | Lane width code |
| is_signed | input | 1 | Selects signed saturation, signed compare and signed pack |
| result | output | 64 | Registered lane-wise result |

## Verification
On every cycle, the assertions check three things:
- reset clears the result;
- every byte of a compare result is either all zeros or all ones, and comparing an operand with itself for equality yields all ones;
- unsigned saturating byte arithmetic never moves a lane in the wrong direction.

Only the directed scenarios can show the exact lane values. These include:
- wraparound at lane boundaries and each clamping limit;
- shift amounts at and beyond the lane width;
- the lane order and clamping of pack;
- that the reserved size and opcode codes behave as stated.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_ADDS  = 4'd1,
        OP_SUB   = 4'd2,
        OP_SUBS  = 4'd3,
        OP_AND   = 4'd4,
        OP_ANDN  = 4'd5,
        OP_OR    = 4'd6,
        OP_XOR   = 4'd7,
        OP_SLL   = 4'd8,
        OP_SRL   = 4'd9,
        OP_SRA   = 4'd10,
        OP_CMPEQ = 4'd11,
        OP_CMPGT = 4'd12,
        OP_PACK  = 4'd13
    } alu_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } lane_sz_e;

    localparam int NUM_SIZES = 3;

endpackage

// File: rtl/simd_lane_ops.sv
module simd_lane_ops
    import simd_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [3:0]   op,
    input  logic         sgn,
    output logic [W-1:0] y
);
    localparam int SW = $clog2(W);
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0]          sum_x;
    logic [W:0]          dif_x;
    logic                add_sovf;
    logic                sub_sovf;
    logic                big_shift;
    logic [SW-1:0]       sh;
    logic signed [W-1:0] a_s;
    logic signed [W-1:0] b_s;
    logic signed [W-1:0] sra_v;

    always_comb begin
        sum_x     = {1'b0, a} + {1'b0, b};
        dif_x     = {1'b0, a} - {1'b0, b};
        add_sovf  = (a[W-1] == b[W-1]) && (sum_x[W-1] != a[W-1]);
        sub_sovf  = (a[W-1] != b[W-1]) && (dif_x[W-1] != a[W-1]);
        big_shift = (b >= W);
        sh        = b[SW-1:0];
        a_s       = a;
        b_s       = b;
        sra_v     = a_s >>> sh;
        y         = '0;
        case (op)
            OP_ADD:  y = sum_x[W-1:0];
            OP_SUB:  y = dif_x[W-1:0];
            OP_ADDS: begin
                if (sgn)           y = add_sovf ? (a[W-1] ? SMIN : SMAX) : sum_x[W-1:0];
                else if (sum_x[W]) y = '1;
                else               y = sum_x[W-1:0];
            end
            OP_SUBS: begin
                if (sgn)           y = sub_sovf ? (a[W-1] ? SMIN : SMAX) : dif_x[W-1:0];
                else if (dif_x[W]) y = '0;
                else               y = dif_x[W-1:0];
            end
            OP_AND:   y = a & b;
            OP_ANDN:  y = ~a & b;
            OP_OR:    y = a | b;
            OP_XOR:   y = a ^ b;
            OP_SLL:   y = big_shift ? '0 : (a << sh);
            OP_SRL:   y = big_shift ? '0 : (a >> sh);
            OP_SRA:   y = big_shift ? {W{a[W-1]}} : sra_v;
            OP_CMPEQ: y = (a == b) ? '1 : '0;
            OP_CMPGT: begin
                if (sgn) y = (a_s > b_s) ? '1 : '0;
                else     y = (a > b) ? '1 : '0;
            end
            default:  y = '0;
        endcase
    end

endmodule

// File: rtl/simd_lane_array.sv
module simd_lane_array #(
    parameter int DW = 64,
    parameter int W  = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [3:0]    op,
    input  logic          sgn,
    output logic [DW-1:0] y
);
    localparam int NL = DW / W;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        simd_lane_ops #(.W(W)) u_lane (
            .a   (a[i*W +: W]),
            .b   (b[i*W +: W]),
            .op  (op),
            .sgn (sgn),
            .y   (y[i*W +: W])
        );
    end

endmodule

// File: rtl/simd_pack_unit.sv
module simd_pack_unit #(
    parameter int DW    = 64,
    parameter int SRC_W = 16
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sgn,
    output logic [DW-1:0] y
);
    localparam int NW   = SRC_W / 2;
    localparam int NL   = DW / SRC_W;
    localparam int HALF = DW / 2;

    function automatic logic [NW-1:0] narrow(input logic [SRC_W-1:0] v, input logic s);
        logic [SRC_W-NW:0] top_s;
        logic [SRC_W-NW-1:0] top_u;
        top_s = v[SRC_W-1:NW-1];
        top_u = v[SRC_W-1:NW];
        if (s) begin
            if ((&top_s) || !(|top_s)) return v[NW-1:0];
            return v[SRC_W-1] ? {1'b1, {(NW-1){1'b0}}} : {1'b0, {(NW-1){1'b1}}};
        end
        if (|top_u) return '1;
        return v[NW-1:0];
    endfunction

    for (genvar i = 0; i < NL; i++) begin : g_narrow
        assign y[i*NW +: NW]        = narrow(a[i*SRC_W +: SRC_W], sgn);
        assign y[HALF + i*NW +: NW] = narrow(b[i*SRC_W +: SRC_W], sgn);
    end

endmodule

// File: rtl/simd_alu.sv
module simd_alu
    import simd_alu_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  logic [3:0]    opcode,
    input  logic [1:0]    lane_size,
    input  logic          is_signed,
    output logic [DW-1:0] result
);
    localparam int NBYTES = DW / 8;

    typedef struct packed {
        logic [DW-1:0] result;
    } state_t;

    state_t        state_d;
    state_t        state_q;
    logic [DW-1:0] lane_res [NUM_SIZES];
    logic [DW-1:0] pack_res [NUM_SIZES];
    logic [1:0]    size_idx;

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        localparam int LW = 8 << g;
        simd_lane_array #(.DW(DW), .W(LW)) u_arr (
            .a   (op_a),
            .b   (op_b),
            .op  (opcode),
            .sgn (is_signed),
            .y   (lane_res[g])
        );
        if (g == 0) begin : g_nopack
            assign pack_res[g] = '0;
        end else begin : g_pack
            simd_pack_unit #(.DW(DW), .SRC_W(LW)) u_pack (
                .a   (op_a),
                .b   (op_b),
                .sgn (is_signed),
                .y   (pack_res[g])
            );
        end
    end

    always_comb begin
        size_idx = (lane_size == SZ_RSVD) ? 2'(SZ_WORD) : lane_size;
        state_d  = state_q;
        case (opcode)
            OP_PACK:             state_d.result = pack_res[size_idx];
            4'd14, 4'd15:        state_d.result = '0;
            default:             state_d.result = lane_res[size_idx];
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign result = state_q.result;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> result == '0); // R1

    AST_EQ_SELF_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(opcode) == OP_CMPEQ && $past(op_a) == $past(op_b)
        |-> result == '1); // R5

    for (genvar i = 0; i < NBYTES; i++) begin : g_chk
        AST_CMP_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && ($past(opcode) == OP_CMPEQ || $past(opcode) == OP_CMPGT)
            |-> (result[i*8 +: 8] == 8'h00 || result[i*8 +: 8] == 8'hFF)); // R5

        AST_UADD_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past(opcode) == OP_ADDS && !$past(is_signed)
            && $past(lane_size) == SZ_BYTE
            |-> result[i*8 +: 8] >= $past(op_a[i*8 +: 8])); // R3

        AST_USUB_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past(opcode) == OP_SUBS && !$past(is_signed)
            && $past(lane_size) == SZ_BYTE
            |-> result[i*8 +: 8] <= $past(op_a[i*8 +: 8])); // R3
    end

endmodule

// File: tb/tb_simd_alu.sv
module tb_simd_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [3:0]  opcode = '0;
    logic [1:0]  lane_size = '0;
    logic        is_signed = 1'b0;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    simd_alu dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_a      (op_a),
        .op_b      (op_b),
        .opcode    (opcode),
        .lane_size (lane_size),
        .is_signed (is_signed),
        .result    (result)
    );

    task automatic check(input logic [63:0] got, input logic [63:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic run(input logic [3:0] op, input logic [1:0] sz, input logic sg,
                       input logic [63:0] a, input logic [63:0] b,
                       input logic [63:0] exp, input string tag);
        @(negedge clk);
        opcode = op; lane_size = sz; is_signed = sg; op_a = a; op_b = b;
        @(posedge clk);
        #2;
        check(result, exp, tag);
    endtask

    task automatic test_reset();
        @(negedge clk);
        op_a = 64'h1111_2222_3333_4444; op_b = 64'h0101_0101_0101_0101;
        opcode = 4'd0;
        repeat (2) @(posedge clk);
        #2;
        check(result, 64'h0, "R1 reset clears result");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic test_wrap();
        run(4'd0, 2'd0, 1'b0, 64'h01FF_7F80_0000_FFFF, 64'h0101_0180_0000_0102,
            64'h0200_8000_0000_0001, "R2 byte wrap add");
        run(4'd0, 2'd1, 1'b0, 64'h01FF_7F80_0000_FFFF, 64'h0101_0180_0000_0102,
            64'h0300_8100_0000_0101, "R2 half wrap add");
        run(4'd0, 2'd2, 1'b0, 64'h01FF_7F80_0000_FFFF, 64'h0101_0180_0000_0102,
            64'h0300_8100_0001_0101, "R2 word wrap add");
        run(4'd0, 2'd3, 1'b1, 64'h01FF_7F80_0000_FFFF, 64'h0101_0180_0000_0102,
            64'h0300_8100_0001_0101, "R2 reserved size acts as word");
        run(4'd2, 2'd0, 1'b0, 64'h0000_0000_0000_0100, 64'h0000_0000_0000_0001,
            64'h0000_0000_0000_01FF, "R2 byte wrap sub no borrow across");
    endtask

    task automatic test_sat();
        run(4'd1, 2'd0, 1'b1, 64'h7F80_10F0_0000_0000, 64'h0180_10F0_0000_0000,
            64'h7F80_20E0_0000_0000, "R3 signed byte sat add");
        run(4'd1, 2'd0, 1'b0, 64'h7F80_10F0_0000_0000, 64'h0180_10F0_0000_0000,
            64'h80FF_20FF_0000_0000, "R3 unsigned byte sat add");
        run(4'd3, 2'd1, 1'b0, 64'h0005_0010_0000_FFFF, 64'h0010_0005_0000_0001,
            64'h0000_000B_0000_FFFE, "R3 unsigned half sat sub");
        run(4'd3, 2'd2, 1'b1, 64'h8000_0000_7FFF_FFFF, 64'h0000_0001_FFFF_FFFF,
            64'h8000_0000_7FFF_FFFF, "R3 signed word sat sub");
    endtask

    task automatic test_logic();
        run(4'd4, 2'd0, 1'b0, 64'hF0F0_F0F0_FF00_FF00, 64'h0FF0_0FF0_F0F0_F0F0,
            64'h00F0_00F0_F000_F000, "R4 and");
        run(4'd5, 2'd2, 1'b0, 64'hF0F0_F0F0_FF00_FF00, 64'h0FF0_0FF0_F0F0_F0F0,
            64'h0F00_0F00_00F0_00F0, "R4 and-not");
        run(4'd6, 2'd1, 1'b1, 64'hF0F0_F0F0_FF00_FF00, 64'h0FF0_0FF0_F0F0_F0F0,
            64'hFFF0_FFF0_FFF0_FFF0, "R4 or");
        run(4'd7, 2'd3, 1'b0, 64'hF0F0_F0F0_FF00_FF00, 64'h0FF0_0FF0_F0F0_F0F0,
            64'hFF00_FF00_0FF0_0FF0, "R4 xor");
    endtask

    task automatic test_shift();
        run(4'd8, 2'd0, 1'b0, 64'h8181_8181_8181_8181, 64'h0001_0708_FF03_0402,
            64'h8102_8000_0008_1004, "R6 byte shift left");
        run(4'd9, 2'd0, 1'b0, 64'h8181_8181_8181_8181, 64'h0001_0708_FF03_0402,
            64'h8140_0100_0010_0820, "R6 byte logical right");
        run(4'd10, 2'd0, 1'b0, 64'h8181_8181_8181_8181, 64'h0001_0708_FF03_0402,
            64'h81C0_FFFF_FFF0_F8E0, "R6 byte arithmetic right");
        run(4'd9, 2'd1, 1'b0, 64'h8000_8000_8000_8000, 64'h000F_0010_0001_0000,
            64'h0001_0000_4000_8000, "R6 half logical right");
        run(4'd10, 2'd1, 1'b0, 64'h8000_8000_8000_8000, 64'h000F_0010_0001_0000,
            64'hFFFF_FFFF_C000_8000, "R6 half arithmetic right");
    endtask

    task automatic test_cmp();
        run(4'd11, 2'd0, 1'b0, 64'h0102_0580_FF00_7F05, 64'h0102_0401_0100_7F06,
            64'hFFFF_0000_00FF_FF00, "R5 byte equal");
        run(4'd12, 2'd0, 1'b0, 64'h0102_0580_FF00_7F05, 64'h0102_0401_0100_7F06,
            64'h0000_FFFF_FF00_0000, "R5 byte unsigned greater");
        run(4'd12, 2'd0, 1'b1, 64'h0102_0580_FF00_7F05, 64'h0102_0401_0100_7F06,
            64'h0000_FF00_0000_0000, "R5 byte signed greater");
        run(4'd11, 2'd2, 1'b0, 64'h1234_5678_0000_0001, 64'h1234_5678_0000_0002,
            64'hFFFF_FFFF_0000_0000, "R5 word equal");
    endtask

    task automatic test_pack();
        run(4'd13, 2'd1, 1'b1, 64'h8000_FF80_0100_0005, 64'h007F_FFFF_FF00_0000,
            64'h7FFF_8000_8080_7F05, "R7 signed pack half to byte");
        run(4'd13, 2'd1, 1'b0, 64'h8000_FF80_0100_0005, 64'h007F_FFFF_FF00_0000,
            64'h7FFF_FF00_FFFF_FF05, "R7 unsigned pack half to byte");
        run(4'd13, 2'd2, 1'b1, 64'hFFFF_0000_0000_7FFF, 64'h0001_0000_FFFF_FFFE,
            64'h7FFF_FFFE_8000_7FFF, "R7 signed pack word to half");
        run(4'd13, 2'd0, 1'b1, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321,
            64'h0, "R7 pack with byte size gives zero");
    endtask

    task automatic test_reserved();
        run(4'd14, 2'd0, 1'b0, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFFF,
            64'h0, "R8 opcode 14 gives zero");
        run(4'd15, 2'd2, 1'b1, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFFF,
            64'h0, "R8 opcode 15 gives zero");
    endtask

    initial begin
        test_reset();
        test_wrap();
        test_sat();
        test_logic();
        test_shift();
        test_cmp();
        test_pack();
        test_reserved();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #160000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete (R1 timing)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule